// File: doc/BRIEF.md
# Ring Interrupt and Control Register Bank

This block is the per-ring register bank that sits between a 32-bit register bus and a ring engine. It collects single-cycle event pulses from the engine into an interrupt status register, filters them through two masks and drives one interrupt line. A status-enable mask decides which events are recorded at all. A signal-enable mask decides which recorded events reach the line. A force register lets software inject an event as if the engine had raised it.

The same bank holds the ring control register, with enable, run/stop and abort bits, and a read-only ring status register. An abort request is held until the engine acknowledges it. A run/stop clear counts as complete once the engine reports it has stopped running. Both completions raise the ring-operation event, so software gets an interrupt for them. Software restarts a halted ring by writing enable alone and then enable with run/stop.

Bus reads are combinational from the address. Writes take effect at the clock edge on which `bus_wr` is high. There is no handshake on the bus: every access completes in one cycle.

Top module: `ring_irq_bank`

## Requirements
- R1: The registers sit at these byte offsets: interrupt status 0x10, status enable 0x14, signal enable 0x18, force 0x1C, ring status 0x20, ring control 0x24. Any other address reads zero, and writes to it change nothing.
- R2: The interrupt status bits are 12 IBI ready, 11 transfer completion, 10 ring operation done, 9 transfer error, 6 IBI ring full and 5 transfer aborted. An event sets its bit at the next clock edge only if the matching status-enable bit is one. Every other bit of the status, status-enable and signal-enable registers reads zero.
- R3: Writing a one to a status bit clears that bit. Writing zero leaves it as it is. If an event and a clear hit the same bit in the same cycle, the event wins.
- R4: `irq` is high exactly when some status bit and its signal-enable bit are both one. Clearing signal enable drops `irq` without clearing any status bit.
- R5: Writing a one to a bit of the force register sets that status bit as if the event had occurred, subject to the status enable. The force register always reads zero.
- R6: Ring control bit 0 is enable, bit 1 is run/stop and bit 2 is abort. They read back and drive `ring_enable`, `ring_run` and `ring_abort` from the cycle after the write. Writing zero clears all three.
- R7: An abort request stays set until `eng_abort_ack` arrives. When the ack arrives, the abort bit self-clears, ring status bit 2 (aborted) sets and the ring-operation event is raised. While the abort is outstanding, ring status bit 3 (locked) reads one. An ack with no abort outstanding is ignored.
- R8: The aborted status bit stays set until a control write with the enable bit set. A control write with enable clear leaves it set.
- R9: A stop completes when `eng_running` falls while the run/stop bit is zero. This raises the ring-operation event.
- R10: Ring status bit 0 reflects the enable bit and bit 1 reflects `eng_running`. After a halted ring sees enable and then enable with run/stop written, `ring_run` is high, and the running bit reads one once the engine reports running.
- R11: After reset, all registers, `irq` and the engine control outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ev_ibi_ready | input | 1 | Engine pulse: IBI status ready |
| ev_xfer_done | input | 1 | Engine pulse: transfer completed |
| ev_xfer_err | input | 1 | Engine pulse: transfer error |
| ev_ibi_full | input | 1 | Engine pulse: IBI ring full |
| ev_xfer_abort | input | 1 | Engine pulse: transfer aborted |
| eng_running | input | 1 | Engine level: ring is running |
| eng_abort_ack | input | 1 | Engine pulse: abort finished |
| ring_enable | output | 1 | Ring enable to the engine |
| ring_run | output | 1 | Run request to the engine |
| ring_abort | output | 1 | Abort request to the engine |
| irq | output | 1 | Interrupt line |

## Verification
The assertions watch several properties on every cycle. The abort bit must self-clear and the aborted status bit must latch on each accepted acknowledge. A write-one-to-clear with no competing event must leave the written bits at zero. A disabled status bit must stay still when its event arrives. A zero signal-enable write must drop the line without disturbing status. A stop completion must record the ring-operation event. The bench scenarios show what a property cannot: the register map and the masking seen at the bus, force read-back as zero, set-over-clear priority in a collision, and the full abort, stop and restart sequences as software would run them.

// File: rtl/ring_irq_pkg.sv
package ring_irq_pkg;
  localparam int DW = 32;

  localparam int B_IBI_RDY  = 12;
  localparam int B_XDONE    = 11;
  localparam int B_RING_OP  = 10;
  localparam int B_XERR     = 9;
  localparam int B_IBI_FULL = 6;
  localparam int B_XABORT   = 5;

  localparam logic [DW-1:0] IMPL_MASK =
    (DW'(1) << B_IBI_RDY) | (DW'(1) << B_XDONE) | (DW'(1) << B_RING_OP) |
    (DW'(1) << B_XERR) | (DW'(1) << B_IBI_FULL) | (DW'(1) << B_XABORT);

  localparam logic [7:0] A_ISTAT = 8'h10;
  localparam logic [7:0] A_STEN  = 8'h14;
  localparam logic [7:0] A_SIGEN = 8'h18;
  localparam logic [7:0] A_FORCE = 8'h1C;
  localparam logic [7:0] A_RSTAT = 8'h20;
  localparam logic [7:0] A_RCTRL = 8'h24;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_ISTAT, SEL_STEN, SEL_SIGEN, SEL_FORCE, SEL_RSTAT, SEL_RCTRL
  } reg_sel_e;
endpackage

// File: rtl/ring_irq_status.sv
module ring_irq_status
  import ring_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ev_vec,
  input  logic          wr_istat,
  input  logic          wr_sten,
  input  logic          wr_sigen,
  input  logic          wr_force,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] istat,
  output logic [DW-1:0] sten,
  output logic [DW-1:0] sigen,
  output logic          irq
);
  logic [DW-1:0] hits;
  logic [DW-1:0] clr;

  always_comb begin
    hits = (ev_vec | (wr_force ? wdata : '0)) & sten & IMPL_MASK;
    clr  = wr_istat ? wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      istat <= '0;
      sten  <= '0;
      sigen <= '0;
    end else begin
      istat <= (istat & ~clr) | hits;
      if (wr_sten)  sten  <= wdata & IMPL_MASK;
      if (wr_sigen) sigen <= wdata & IMPL_MASK;
    end
  end

  assign irq = |(istat & sigen);
endmodule

// File: rtl/ring_ctrl_unit.sv
module ring_ctrl_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic [2:0] wbits,
  input  logic       eng_running,
  input  logic       eng_abort_ack,
  output logic       en_q,
  output logic       run_q,
  output logic       abort_q,
  output logic       aborted_q,
  output logic       ring_op_evt
);
  logic run_seen_q;
  logic abort_done;
  logic stop_done;

  always_comb begin
    abort_done  = abort_q && eng_abort_ack;
    stop_done   = run_seen_q && !eng_running && !run_q;
    ring_op_evt = abort_done || stop_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      run_q      <= 1'b0;
      abort_q    <= 1'b0;
      aborted_q  <= 1'b0;
      run_seen_q <= 1'b0;
    end else begin
      run_seen_q <= eng_running;
      if (wr_ctrl) begin
        en_q    <= wbits[0];
        run_q   <= wbits[1];
        abort_q <= wbits[2];
      end else if (abort_done) begin
        abort_q <= 1'b0;
      end
      if (wr_ctrl && wbits[0])
        aborted_q <= 1'b0;
      else if (abort_done)
        aborted_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ring_irq_bank.sv
module ring_irq_bank
  import ring_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ev_ibi_ready,
  input  logic              ev_xfer_done,
  input  logic              ev_xfer_err,
  input  logic              ev_ibi_full,
  input  logic              ev_xfer_abort,
  input  logic              eng_running,
  input  logic              eng_abort_ack,
  output logic              ring_enable,
  output logic              ring_run,
  output logic              ring_abort,
  output logic              irq
);
  localparam int AW_PAD = (ADDR_W > 8) ? ADDR_W : 8;

  reg_sel_e      sel;
  logic [DW-1:0] ev_vec;
  logic [DW-1:0] istat, sten, sigen;
  logic          aborted;
  logic          ring_op_evt;
  logic [AW_PAD-1:0] addr_x;

  assign addr_x = AW_PAD'(bus_addr);

  always_comb begin
    sel = SEL_NONE;
    if (addr_x[AW_PAD-1:8] == '0) begin
      case (addr_x[7:0])
        A_ISTAT: sel = SEL_ISTAT;
        A_STEN:  sel = SEL_STEN;
        A_SIGEN: sel = SEL_SIGEN;
        A_FORCE: sel = SEL_FORCE;
        A_RSTAT: sel = SEL_RSTAT;
        A_RCTRL: sel = SEL_RCTRL;
        default: sel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    ev_vec             = '0;
    ev_vec[B_IBI_RDY]  = ev_ibi_ready;
    ev_vec[B_XDONE]    = ev_xfer_done;
    ev_vec[B_RING_OP]  = ring_op_evt;
    ev_vec[B_XERR]     = ev_xfer_err;
    ev_vec[B_IBI_FULL] = ev_ibi_full;
    ev_vec[B_XABORT]   = ev_xfer_abort;
  end

  ring_irq_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_vec   (ev_vec),
    .wr_istat (bus_wr && sel == SEL_ISTAT),
    .wr_sten  (bus_wr && sel == SEL_STEN),
    .wr_sigen (bus_wr && sel == SEL_SIGEN),
    .wr_force (bus_wr && sel == SEL_FORCE),
    .wdata    (bus_wdata),
    .istat    (istat),
    .sten     (sten),
    .sigen    (sigen),
    .irq      (irq)
  );

  ring_ctrl_unit u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_ctrl       (bus_wr && sel == SEL_RCTRL),
    .wbits         (bus_wdata[2:0]),
    .eng_running   (eng_running),
    .eng_abort_ack (eng_abort_ack),
    .en_q          (ring_enable),
    .run_q         (ring_run),
    .abort_q       (ring_abort),
    .aborted_q     (aborted),
    .ring_op_evt   (ring_op_evt)
  );

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_ISTAT: bus_rdata = istat;
      SEL_STEN:  bus_rdata = sten;
      SEL_SIGEN: bus_rdata = sigen;
      SEL_RSTAT: bus_rdata = {28'd0, ring_abort, aborted, eng_running, ring_enable};
      SEL_RCTRL: bus_rdata = {29'd0, ring_abort, ring_run, ring_enable};
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ring_irq_bank_chk.sv
module ring_irq_bank_chk
  import ring_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              ev_ibi_ready,
  input logic              eng_running,
  input logic              eng_abort_ack,
  input logic              ring_run,
  input logic              ring_abort,
  input logic              irq,
  input logic [DW-1:0]     istat,
  input logic [DW-1:0]     sten,
  input logic              aborted,
  input logic              ring_op_evt,
  input logic [DW-1:0]     ev_vec
);
  logic wr_istat, wr_sigen, wr_force, wr_ctrl;
  assign wr_istat = bus_wr && (32'(bus_addr) == 32'(A_ISTAT));
  assign wr_sigen = bus_wr && (32'(bus_addr) == 32'(A_SIGEN));
  assign wr_force = bus_wr && (32'(bus_addr) == 32'(A_FORCE));
  assign wr_ctrl  = bus_wr && (32'(bus_addr) == 32'(A_RCTRL));

  // R7: abort request drops once the engine acknowledges
  p_abort_selfclear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_abort && eng_abort_ack && !wr_ctrl) |=> !ring_abort);

  // R7: aborted state latches on an accepted acknowledge
  p_aborted_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_abort && eng_abort_ack && !wr_ctrl) |=> aborted);

  // R3: written ones clear when no event competes
  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_istat && ev_vec == '0) |=> ((istat & $past(bus_wdata)) == '0));

  // R2: disabled status bit ignores its event
  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ibi_ready && !sten[B_IBI_RDY] && !bus_wr) |=> $stable(istat[B_IBI_RDY]));

  // R4: zero signal enable drops the line and keeps status
  p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sigen && bus_wdata == '0 && ev_vec == '0) |=> (!irq && $stable(istat)));

  // R9: a finished stop records the ring-operation event
  p_stop_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(eng_running) && !ring_run && sten[B_RING_OP] && !wr_force && !bus_wr)
      |-> ring_op_evt);

  // R5: force sets enabled bits at the next edge
  p_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_force) |=> ((istat & $past(bus_wdata & sten)) == $past(bus_wdata & sten)));
endmodule

bind ring_irq_bank ring_irq_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_wr        (bus_wr),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .ev_ibi_ready  (ev_ibi_ready),
  .eng_running   (eng_running),
  .eng_abort_ack (eng_abort_ack),
  .ring_run      (ring_run),
  .ring_abort    (ring_abort),
  .irq           (irq),
  .istat         (istat),
  .sten          (sten),
  .aborted       (aborted),
  .ring_op_evt   (ring_op_evt),
  .ev_vec        (ev_vec)
);

// File: tb/tb_ring_irq_bank.sv
`timescale 1ns/1ps
module tb_ring_irq_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic ev_ibi_ready = 0, ev_xfer_done = 0, ev_xfer_err = 0, ev_ibi_full = 0, ev_xfer_abort = 0;
  logic eng_running = 0, eng_abort_ack = 0;
  logic ring_enable, ring_run, ring_abort, irq;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  ring_irq_bank #(.ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_ibi_ready(ev_ibi_ready), .ev_xfer_done(ev_xfer_done),
    .ev_xfer_err(ev_xfer_err), .ev_ibi_full(ev_ibi_full),
    .ev_xfer_abort(ev_xfer_abort), .eng_running(eng_running),
    .eng_abort_ack(eng_abort_ack), .ring_enable(ring_enable),
    .ring_run(ring_run), .ring_abort(ring_abort), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  // {is_write, addr, data/expected}
  localparam int NV = 17;
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 8'h10, 32'h0},          // R11 reset status
    {1'b0, 8'h24, 32'h0},          // R11 reset control
    {1'b1, 8'h14, 32'hFFFF_FFFF},
    {1'b0, 8'h14, 32'h0000_1E60},  // R2 implemented bits only
    {1'b1, 8'h1C, 32'h0000_0820},
    {1'b0, 8'h1C, 32'h0},          // R5 force reads zero
    {1'b0, 8'h10, 32'h0000_0820},  // R5 force sets bits
    {1'b1, 8'h10, 32'h0000_0800},
    {1'b0, 8'h10, 32'h0000_0020},  // R3 w1c
    {1'b1, 8'h18, 32'h0000_0020},
    {1'b0, 8'h18, 32'h0000_0020},  // R1 signal enable
    {1'b1, 8'h40, 32'hFFFF_FFFF},
    {1'b0, 8'h40, 32'h0},          // R1 unmapped
    {1'b1, 8'h24, 32'h0000_0003},
    {1'b0, 8'h24, 32'h0000_0003},  // R6 control readback
    {1'b0, 8'h20, 32'h0000_0001},  // R10 enabled, not running
    {1'b1, 8'h24, 32'h0}
  };

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    check("R11 irq", {31'd0, irq}, 32'd0);
    check("R11 outs", {29'd0, ring_enable, ring_run, ring_abort}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40]) wr(VEC[i][39:32], VEC[i][31:0]);
      else rchk($sformatf("R1/vector %0d", i), VEC[i][39:32], VEC[i][31:0]);
    end

    // R6: writing zero clears outputs
    check("R6 outs", {29'd0, ring_enable, ring_run, ring_abort}, 32'd0);

    // R4: irq from status bit 5 with signal enable bit 5
    @(negedge clk);
    check("R4 irq on", {31'd0, irq}, 32'd1);
    wr(8'h18, 32'h0);
    check("R4 irq off", {31'd0, irq}, 32'd0);
    rchk("R4 status kept", 8'h10, 32'h0000_0020);
    wr(8'h10, 32'hFFFF_FFFF);
    rchk("R3 clear all", 8'h10, 32'h0);

    // R2: events set their bits
    @(negedge clk);
    ev_ibi_ready = 1; ev_xfer_done = 1; ev_xfer_err = 1; ev_ibi_full = 1; ev_xfer_abort = 1;
    @(negedge clk);
    ev_ibi_ready = 0; ev_xfer_done = 0; ev_xfer_err = 0; ev_ibi_full = 0; ev_xfer_abort = 0;
    rchk("R2 events", 8'h10, 32'h0000_1A60);
    wr(8'h10, 32'hFFFF_FFFF);

    // R2 gating by status enable; R5 force gated too
    wr(8'h14, 32'h0);
    @(negedge clk); ev_ibi_ready = 1;
    @(negedge clk); ev_ibi_ready = 0;
    wr(8'h1C, 32'h0000_0800);
    rchk("R2/R5 gated", 8'h10, 32'h0);
    wr(8'h14, 32'hFFFF_FFFF);

    // R3: event wins over clear in the same cycle
    wr(8'h1C, 32'h0000_1000);
    @(negedge clk);
    bus_wr = 1; bus_addr = 8'h10; bus_wdata = 32'h0000_1000; ev_ibi_ready = 1;
    @(negedge clk);
    bus_wr = 0; bus_wdata = '0; ev_ibi_ready = 0;
    rchk("R3 set wins", 8'h10, 32'h0000_1000);
    wr(8'h10, 32'hFFFF_FFFF);

    // R7: stray ack ignored
    @(negedge clk); eng_abort_ack = 1;
    @(negedge clk); eng_abort_ack = 0;
    rchk("R7 stray ack", 8'h10, 32'h0);

    // R7: abort handshake
    wr(8'h24, 32'h1);
    wr(8'h24, 32'h5);
    check("R7 abort out", {31'd0, ring_abort}, 32'd1);
    rchk("R7 locked", 8'h20, 32'h0000_0009);
    @(negedge clk); eng_abort_ack = 1;
    @(negedge clk); eng_abort_ack = 0;
    check("R7 abort cleared", {31'd0, ring_abort}, 32'd0);
    rchk("R7 aborted status", 8'h20, 32'h0000_0005);
    rchk("R7 ring op", 8'h10, 32'h0000_0400);
    wr(8'h10, 32'h0000_0400);

    // R8: aborted persists until enable written
    wr(8'h24, 32'h0);
    rchk("R8 kept", 8'h20, 32'h0000_0004);
    wr(8'h24, 32'h1);
    rchk("R8 cleared", 8'h20, 32'h0000_0001);

    // R10: restart, engine reports running
    wr(8'h24, 32'h3);
    check("R10 run out", {31'd0, ring_run}, 32'd1);
    @(negedge clk); eng_running = 1;
    rchk("R10 running", 8'h20, 32'h0000_0003);

    // R9: stop completes when engine stops
    wr(8'h24, 32'h1);
    rchk("R9 not yet", 8'h10, 32'h0);
    @(negedge clk); eng_running = 0;
    @(negedge clk);
    rchk("R9 ring op", 8'h10, 32'h0000_0400);
    wr(8'h18, 32'h0000_0400);
    @(negedge clk);
    check("R4 irq ring op", {31'd0, irq}, 32'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule